// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the serial test port of a chip. It is clocked by the test clock, steered by the mode-select input alone, and it connects one of several shift registers between the serial data input and the serial data output. Inside it sits the sixteen-state port sequencer, a four-bit instruction register, a one-bit pass-through register and a 32-bit identification register. The boundary-scan chain lives outside the block. The controller gives that chain capture, shift and update strobes, a one-hot instruction-select vector, and a flag that lets the chain's values drive the pins.

A tester moves the sequencer through the capture, shift and update phases to load an instruction. It then moves through the same phases on the data side to read or write the register that the instruction selects. The serial output changes on the falling edge of the test clock. It is enabled only while a register is being shifted, so several devices can share one scan path.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: On each rising edge of `tck` the sequencer moves to the next state chosen by `tms` alone, following the standard sixteen-state graph. `tap_state` shows the state with these codes: reset F, idle C, select-DR 7, capture-DR 6, shift-DR 2, exit1-DR 1, pause-DR 3, exit2-DR 0, update-DR 5, select-IR 4, capture-IR E, shift-IR A, exit1-IR 9, pause-IR B, exit2-IR 8, update-IR D.
- R2: Five consecutive rising edges with `tms` high bring the sequencer to the reset state (F), whatever state it started in.
- R3: `trst_n` low forces the reset state at once, without waiting for a clock edge. It also makes IDCODE the active instruction and drives `tdo` and `tdo_oe` low. This holds even while the sequencer is in update-IR.
- R4: The instruction register is 4 bits wide. Capture-IR loads 4'b0101, so the two low bits read 01. Shift-IR moves the register one place toward its least significant bit, which appears first on `tdo`, with `tdi` entering at the top. The shifted value becomes the active instruction on the edge that leaves update-IR.
- R5: Each rising edge taken in the reset state makes IDCODE the active instruction.
- R6: Opcodes: EXTEST 4'b0000, SAMPLE/PRELOAD 4'b0001, IDCODE 4'b0010, BYPASS 4'b1111. Every other code acts as BYPASS. `instr_sel` is one-hot, with bit 0 for EXTEST, bit 1 for SAMPLE/PRELOAD, bit 2 for IDCODE and bit 3 for BYPASS.
- R7: Under BYPASS, capture-DR loads 0 into the one-bit register. Each bit shifted in on `tdi` appears on `tdo` one shift later.
- R8: Under IDCODE, capture-DR loads the 32-bit value 32'h2B7D4A13, which is shifted out least significant bit first. Its fields are version [31:28], part [27:12], maker [11:1] and a constant 1 in bit 0.
- R9: Under EXTEST or SAMPLE/PRELOAD, `bsr_capture`, `bsr_shift` and `bsr_update` are high exactly in capture-DR, shift-DR and update-DR, and `tdo` carries `bsr_tdo`. Under the other instructions these strobes stay low.
- R10: `extest_mode` is high only while EXTEST is the active instruction.
- R11: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high exactly for the half-cycles that follow a falling edge taken in shift-DR or shift-IR. While `tdo_oe` is low, `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous port reset, active low |
| tms | input | 1 | Mode select, steers the sequencer |
| tdi | input | 1 | Serial data in |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| tap_state | output | 4 | Current sequencer state code |
| instr_sel | output | 4 | One-hot active instruction |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| extest_mode | output | 1 | Boundary values drive the pins |

## Verification
Two actions can land on the same moment: an asynchronous port reset and the instruction update that the update-IR edge would perform. The bench shifts EXTEST into the instruction register and stops in update-IR. It pulls `trst_n` low before the next rising edge and expects IDCODE to be active and `extest_mode` to stay low. A control run of the same sequence without the reset expects EXTEST to take effect.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    TAP_EXIT2_DR   = 4'h0,
    TAP_EXIT1_DR   = 4'h1,
    TAP_SHIFT_DR   = 4'h2,
    TAP_PAUSE_DR   = 4'h3,
    TAP_SELECT_IR  = 4'h4,
    TAP_UPDATE_DR  = 4'h5,
    TAP_CAPTURE_DR = 4'h6,
    TAP_SELECT_DR  = 4'h7,
    TAP_EXIT2_IR   = 4'h8,
    TAP_EXIT1_IR   = 4'h9,
    TAP_SHIFT_IR   = 4'hA,
    TAP_PAUSE_IR   = 4'hB,
    TAP_IDLE       = 4'hC,
    TAP_UPDATE_IR  = 4'hD,
    TAP_CAPTURE_IR = 4'hE,
    TAP_RESET      = 4'hF
  } tap_state_e;

  // one-hot instruction-select positions
  localparam int SEL_EXTEST = 0;
  localparam int SEL_SAMPLE = 1;
  localparam int SEL_IDCODE = 2;
  localparam int SEL_BYPASS = 3;
  localparam int SEL_W      = 4;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      TAP_RESET:      n = m ? TAP_RESET     : TAP_IDLE;
      TAP_IDLE:       n = m ? TAP_SELECT_DR : TAP_IDLE;
      TAP_SELECT_DR:  n = m ? TAP_SELECT_IR : TAP_CAPTURE_DR;
      TAP_CAPTURE_DR: n = m ? TAP_EXIT1_DR  : TAP_SHIFT_DR;
      TAP_SHIFT_DR:   n = m ? TAP_EXIT1_DR  : TAP_SHIFT_DR;
      TAP_EXIT1_DR:   n = m ? TAP_UPDATE_DR : TAP_PAUSE_DR;
      TAP_PAUSE_DR:   n = m ? TAP_EXIT2_DR  : TAP_PAUSE_DR;
      TAP_EXIT2_DR:   n = m ? TAP_UPDATE_DR : TAP_SHIFT_DR;
      TAP_UPDATE_DR:  n = m ? TAP_SELECT_DR : TAP_IDLE;
      TAP_SELECT_IR:  n = m ? TAP_RESET     : TAP_CAPTURE_IR;
      TAP_CAPTURE_IR: n = m ? TAP_EXIT1_IR  : TAP_SHIFT_IR;
      TAP_SHIFT_IR:   n = m ? TAP_EXIT1_IR  : TAP_SHIFT_IR;
      TAP_EXIT1_IR:   n = m ? TAP_UPDATE_IR : TAP_PAUSE_IR;
      TAP_PAUSE_IR:   n = m ? TAP_EXIT2_IR  : TAP_PAUSE_IR;
      TAP_EXIT2_IR:   n = m ? TAP_UPDATE_IR : TAP_SHIFT_IR;
      TAP_UPDATE_IR:  n = m ? TAP_SELECT_DR : TAP_IDLE;
      default:        n = TAP_RESET;
    endcase
    return n;
  endfunction

  function automatic logic in_shift(input tap_state_e s);
    return (s == TAP_SHIFT_DR) || (s == TAP_SHIFT_IR);
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state,
  output logic       ev_reset,
  output logic       ev_capture_dr,
  output logic       ev_shift_dr,
  output logic       ev_update_dr,
  output logic       ev_capture_ir,
  output logic       ev_shift_ir,
  output logic       ev_update_ir
);

  tap_state_e state_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= TAP_RESET;
    else         state_q <= tap_next(state_q, tms);
  end

  assign state         = state_q;
  assign ev_reset      = (state_q == TAP_RESET);
  assign ev_capture_dr = (state_q == TAP_CAPTURE_DR);
  assign ev_shift_dr   = (state_q == TAP_SHIFT_DR);
  assign ev_update_dr  = (state_q == TAP_UPDATE_DR);
  assign ev_capture_ir = (state_q == TAP_CAPTURE_IR);
  assign ev_shift_ir   = (state_q == TAP_SHIFT_IR);
  assign ev_update_ir  = (state_q == TAP_UPDATE_IR);

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir #(
  parameter int                  IR_W        = 4,
  parameter logic [IR_W-1:0]     CAPTURE_PAT = 4'b0101,
  parameter logic [IR_W-1:0]     RESET_OP    = 4'b0010
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            ev_reset,
  input  logic            ev_capture_ir,
  input  logic            ev_shift_ir,
  input  logic            ev_update_ir,
  output logic [IR_W-1:0] ir_shift,
  output logic [IR_W-1:0] ir_active
);

  logic [IR_W-1:0] shift_q;
  logic [IR_W-1:0] active_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)            shift_q <= CAPTURE_PAT;
    else if (ev_capture_ir) shift_q <= CAPTURE_PAT;
    else if (ev_shift_ir)   shift_q <= {tdi, shift_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           active_q <= RESET_OP;
    else if (ev_reset)     active_q <= RESET_OP;
    else if (ev_update_ir) active_q <= shift_q;
  end

  assign ir_shift  = shift_q;
  assign ir_active = active_q;

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr #(
  parameter int               ID_W     = 32,
  parameter logic [ID_W-1:0]  ID_VALUE = 32'h2B7D_4A13
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic ev_capture_dr,
  input  logic ev_shift_dr,
  input  logic sel_bypass,
  input  logic sel_idcode,
  output logic bypass_out,
  output logic idcode_out
);

  logic            bypass_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) bypass_q <= 1'b0;
    else if (sel_bypass) begin
      if (ev_capture_dr)    bypass_q <= 1'b0;
      else if (ev_shift_dr) bypass_q <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) id_q <= ID_VALUE;
    else if (sel_idcode) begin
      if (ev_capture_dr)    id_q <= ID_VALUE;
      else if (ev_shift_dr) id_q <= {tdi, id_q[ID_W-1:1]};
    end
  end

  assign bypass_out = bypass_q;
  assign idcode_out = id_q[0];

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W        = 4,
  parameter logic [IR_W-1:0] OP_EXTEST   = 4'b0000,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 4'b0001,
  parameter logic [IR_W-1:0] OP_IDCODE   = 4'b0010,
  parameter logic [IR_W-1:0] IR_CAPTURE  = 4'b0101,
  parameter int              ID_W        = 32,
  parameter logic [ID_W-1:0] ID_VALUE    = 32'h2B7D_4A13
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic             bsr_tdo,
  output logic             tdo,
  output logic             tdo_oe,
  output logic [3:0]       tap_state,
  output logic [SEL_W-1:0] instr_sel,
  output logic             bsr_capture,
  output logic             bsr_shift,
  output logic             bsr_update,
  output logic             extest_mode
);

  tap_state_e      state;
  logic            ev_reset, ev_capture_dr, ev_shift_dr, ev_update_dr;
  logic            ev_capture_ir, ev_shift_ir, ev_update_ir;
  logic [IR_W-1:0] ir_shift;
  logic [IR_W-1:0] ir_active;
  logic [SEL_W-1:0] sel;
  logic            bsr_path;
  logic            bypass_out, idcode_out;
  logic            dr_bit, tdo_next;
  logic            tdo_q, oe_q;

  jtag_tap_fsm u_fsm (
    .tck           (tck),
    .trst_n        (trst_n),
    .tms           (tms),
    .state         (state),
    .ev_reset      (ev_reset),
    .ev_capture_dr (ev_capture_dr),
    .ev_shift_dr   (ev_shift_dr),
    .ev_update_dr  (ev_update_dr),
    .ev_capture_ir (ev_capture_ir),
    .ev_shift_ir   (ev_shift_ir),
    .ev_update_ir  (ev_update_ir)
  );

  jtag_tap_ir #(
    .IR_W        (IR_W),
    .CAPTURE_PAT (IR_CAPTURE),
    .RESET_OP    (OP_IDCODE)
  ) u_ir (
    .tck           (tck),
    .trst_n        (trst_n),
    .tdi           (tdi),
    .ev_reset      (ev_reset),
    .ev_capture_ir (ev_capture_ir),
    .ev_shift_ir   (ev_shift_ir),
    .ev_update_ir  (ev_update_ir),
    .ir_shift      (ir_shift),
    .ir_active     (ir_active)
  );

  // decode: any unassigned opcode falls into the pass-through path
  always_comb begin
    sel = '0;
    if      (ir_active == OP_EXTEST) sel[SEL_EXTEST] = 1'b1;
    else if (ir_active == OP_SAMPLE) sel[SEL_SAMPLE] = 1'b1;
    else if (ir_active == OP_IDCODE) sel[SEL_IDCODE] = 1'b1;
    else                             sel[SEL_BYPASS] = 1'b1;
  end

  jtag_tap_dr #(
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck           (tck),
    .trst_n        (trst_n),
    .tdi           (tdi),
    .ev_capture_dr (ev_capture_dr),
    .ev_shift_dr   (ev_shift_dr),
    .sel_bypass    (sel[SEL_BYPASS]),
    .sel_idcode    (sel[SEL_IDCODE]),
    .bypass_out    (bypass_out),
    .idcode_out    (idcode_out)
  );

  assign bsr_path = sel[SEL_EXTEST] | sel[SEL_SAMPLE];

  always_comb begin
    if (bsr_path)              dr_bit = bsr_tdo;
    else if (sel[SEL_IDCODE])  dr_bit = idcode_out;
    else                       dr_bit = bypass_out;
  end

  always_comb begin
    if (ev_shift_ir)      tdo_next = ir_shift[0];
    else if (ev_shift_dr) tdo_next = dr_bit;
    else                  tdo_next = 1'b0;
  end

  // output stage retimed to the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_next;
      oe_q  <= in_shift(state);
    end
  end

  assign tdo         = tdo_q;
  assign tdo_oe      = oe_q;
  assign tap_state   = state;
  assign instr_sel   = sel;
  assign bsr_capture = bsr_path & ev_capture_dr;
  assign bsr_shift   = bsr_path & ev_shift_dr;
  assign bsr_update  = bsr_path & ev_update_dr;
  assign extest_mode = sel[SEL_EXTEST];

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
#(
  parameter int IR_W = 4
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input logic [3:0]      tap_state,
  input logic [IR_W-1:0] ir_shift,
  input logic [IR_W-1:0] ir_active,
  input logic [3:0]      instr_sel,
  input logic            tdo_oe,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            extest_mode
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           ones_cnt <= '0;
    else if (!tms)         ones_cnt <= '0;
    else if (ones_cnt < 5) ones_cnt <= ones_cnt + 3'd1;
  end

  // R2
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt >= 3'd5) |-> (tap_state == TAP_RESET));

  // R1
  capture_to_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == TAP_CAPTURE_DR && !tms) |=> (tap_state == TAP_SHIFT_DR));

  // R11
  tdo_oe_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((tap_state == TAP_SHIFT_DR) || (tap_state == TAP_SHIFT_IR)));

  // R6
  instr_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $countones(instr_sel) == 1);

  // R4
  capture_ir_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == TAP_CAPTURE_IR) |=> (ir_shift[1:0] == 2'b01));

  // R4
  update_ir_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == TAP_UPDATE_IR) |=> (ir_active == $past(ir_shift)));

  // R5
  reset_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == TAP_RESET) |=> (instr_sel == 4'b0100));

  // R9
  strobe_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  // R10
  extest_sel_chk: assert property (@(posedge tck) disable iff (!trst_n)
    extest_mode |-> instr_sel[0]);

endmodule

bind jtag_tap_ctrl jtag_tap_chk #(.IR_W(IR_W)) u_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .tms         (tms),
  .tap_state   (tap_state),
  .ir_shift    (ir_shift),
  .ir_active   (ir_active),
  .instr_sel   (instr_sel),
  .tdo_oe      (tdo_oe),
  .bsr_capture (bsr_capture),
  .bsr_shift   (bsr_shift),
  .bsr_update  (bsr_update),
  .extest_mode (extest_mode)
);

// File: tb/jtag_tap_ctrl_bench.sv
`timescale 1ns/100ps
module jtag_tap_ctrl_bench;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       bsr_tdo;
  logic       tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, extest_mode;
  logic [3:0] tap_state, instr_sel;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  localparam logic [31:0] ID_EXP = 32'h2B7D_4A13;

  always #2 tck = ~tck;

  jtag_tap_ctrl u_jtag_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo),
    .tdo(tdo), .tdo_oe(tdo_oe), .tap_state(tap_state), .instr_sel(instr_sel),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .extest_mode(extest_mode)
  );

  // model of an 8-cell external boundary chain
  logic [7:0] chain = 8'h00;
  always @(posedge tck) begin
    if (bsr_capture)    chain <= 8'hC3;
    else if (bsr_shift) chain <= {tdi, chain[7:1]};
  end
  assign bsr_tdo = chain[0];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench view of the state graph: {next on tms=1, next on tms=0}
  function automatic logic [3:0] model_next(input logic [3:0] s, input logic m);
    logic [7:0] pair;
    case (s)
      4'hF: pair = 8'hFC;  4'hC: pair = 8'h7C;
      4'h7: pair = 8'h46;  4'h6: pair = 8'h12;
      4'h2: pair = 8'h12;  4'h1: pair = 8'h53;
      4'h3: pair = 8'h03;  4'h0: pair = 8'h52;
      4'h5: pair = 8'h7C;  4'h4: pair = 8'hFE;
      4'hE: pair = 8'h9A;  4'hA: pair = 8'h9A;
      4'h9: pair = 8'hDB;  4'hB: pair = 8'h8B;
      4'h8: pair = 8'hDA;  default: pair = 8'h7C;
    endcase
    return m ? pair[7:4] : pair[3:0];
  endfunction

  task automatic clk_step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    #0.5;
  endtask

  logic [31:0] sh_out;
  int          oe_cnt, sh_seen;
  bit          cap_seen, upd_seen;

  // from idle: capture, shift n bits, update, back to idle
  task automatic run_shift(input bit is_ir, input int n, input logic [31:0] din);
    sh_out = '0; oe_cnt = 0; sh_seen = 0;
    clk_step(1, 0);
    if (is_ir) clk_step(1, 0);
    clk_step(0, 0);
    cap_seen = bsr_capture;
    clk_step(0, 0);
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #0.5;
      sh_out[i] = tdo;
      if (tdo_oe) oe_cnt++;
      if (bsr_shift) sh_seen++;
      clk_step(i == n - 1, din[i]);
    end
    clk_step(1, 0);
    upd_seen = bsr_update;
    clk_step(0, 0);
  endtask

  task automatic load_ir(input logic [3:0] op);
    run_shift(1, 4, {28'b0, op});
  endtask

  task automatic five_ones();
    for (int i = 0; i < 5; i++) clk_step(1, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] cov;
    logic [3:0]  mstate;
    #5;
    // R3 reset state
    check(tap_state == 4'hF, "R3 state in reset", tap_state, 4'hF);
    check(tdo_oe == 0 && tdo == 0, "R3 tdo idle", {tdo, tdo_oe}, 0);
    check(instr_sel == 4'b0100, "R3 idcode active", instr_sel, 4'b0100);
    #4 trst_n = 1'b1;
    @(posedge tck); #0.5;
    clk_step(0, 0);
    check(tap_state == 4'hC, "R1 idle", tap_state, 4'hC);

    // R11 output enable follows the falling edge
    clk_step(1, 0); clk_step(0, 0); clk_step(0, 0);
    check(tdo_oe == 0, "R11 oe before falling edge", tdo_oe, 0);
    @(negedge tck); #0.5;
    check(tdo_oe == 1, "R11 oe after falling edge", tdo_oe, 1);
    five_ones();
    check(tap_state == 4'hF, "R2 five ones from shift-DR", tap_state, 4'hF);
    clk_step(0, 0);

    // R8 identification read
    run_shift(0, 32, 32'h0);
    check(sh_out == ID_EXP, "R8 idcode value", sh_out, ID_EXP);
    check(oe_cnt == 32, "R11 oe during shift", oe_cnt, 32);
    check(sh_seen == 0 && !cap_seen, "R9 no strobes under idcode", sh_seen, 0);

    // R4 capture pattern, R6 bypass select
    load_ir(4'b1111);
    check(sh_out[3:0] == 4'b0101, "R4 capture-IR pattern", sh_out[3:0], 4'b0101);
    check(instr_sel == 4'b1000, "R6 bypass select", instr_sel, 4'b1000);

    // R7 one-bit pass-through
    run_shift(0, 8, 32'hB4);
    check(sh_out[7:0] == 8'h68, "R7 bypass delay", sh_out[7:0], 8'h68);

    // R6 unassigned opcode
    load_ir(4'b0111);
    check(instr_sel == 4'b1000, "R6 unassigned as bypass", instr_sel, 4'b1000);
    run_shift(0, 8, 32'h5A);
    check(sh_out[7:0] == 8'hB4, "R6 unassigned shifts one bit", sh_out[7:0], 8'hB4);

    // R9 R10 sample/preload
    load_ir(4'b0001);
    check(instr_sel == 4'b0010 && !extest_mode, "R10 sample keeps pins", {instr_sel, extest_mode}, 8'h4);
    run_shift(0, 8, 32'h3C);
    check(sh_out[7:0] == 8'hC3, "R9 chain data on tdo", sh_out[7:0], 8'hC3);
    check(cap_seen && upd_seen && sh_seen == 8, "R9 strobes", {cap_seen, upd_seen, sh_seen[7:0]}, 10'h308);

    // R10 extest
    load_ir(4'b0000);
    check(instr_sel == 4'b0001 && extest_mode, "R10 extest drives pins", {instr_sel, extest_mode}, 8'h3);
    run_shift(0, 8, 32'h00);
    check(sh_out[7:0] == 8'hC3, "R9 extest chain path", sh_out[7:0], 8'hC3);

    // R5 reset state restores idcode
    five_ones();
    clk_step(1, 0);
    check(instr_sel == 4'b0100 && !extest_mode, "R5 idcode after reset state", instr_sel, 4'b0100);
    clk_step(0, 0);

    // R3 with R4: async reset in the same cycle as update-IR
    clk_step(1, 0); clk_step(1, 0); clk_step(0, 0); clk_step(0, 0);
    for (int i = 0; i < 4; i++) clk_step(i == 3, 1'b0);
    clk_step(1, 0);
    check(tap_state == 4'hD, "R4 reached update-IR", tap_state, 4'hD);
    trst_n = 1'b0;
    #1;
    check(tap_state == 4'hF, "R3 async reset in update-IR", tap_state, 4'hF);
    check(instr_sel == 4'b0100 && !extest_mode, "R3 reset beats update", instr_sel, 4'b0100);
    trst_n = 1'b1;
    @(posedge tck); #0.5;
    clk_step(0, 0);
    // control: the same sequence without reset
    clk_step(1, 0); clk_step(1, 0); clk_step(0, 0); clk_step(0, 0);
    for (int i = 0; i < 4; i++) clk_step(i == 3, 1'b0);
    clk_step(1, 0);
    check(instr_sel == 4'b0100, "R4 not active before update edge", instr_sel, 4'b0100);
    clk_step(0, 0);
    check(instr_sel == 4'b0001, "R4 active after update edge", instr_sel, 4'b0001);

    // R1 R2 walk of the state graph
    five_ones();
    mstate = 4'hF;
    lfsr = 16'hACE1;
    cov = '0;
    for (int k = 0; k < 800; k++) begin
      logic m;
      m = lfsr[0] ^ lfsr[5];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cov[{mstate, m}] = 1'b1;
      mstate = model_next(mstate, m);
      clk_step(m, lfsr[3]);
      check(tap_state == mstate, "R1 transition", tap_state, mstate);
      if (k % 37 == 36) begin
        five_ones();
        mstate = 4'hF;
        check(tap_state == 4'hF, "R2 five ones", tap_state, 4'hF);
      end
    end
    check(cov == 32'hFFFF_FFFF, "R1 all arcs taken", cov, 32'hFFFF_FFFF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule